// File: doc/BRIEF.md
# Two-Parallel Fast FIR Filter

This block runs a fixed M-tap FIR response over a stream that arrives two samples per clock. Each accepted clock carries an earlier sample on the even lane and a later sample on the odd lane. Each accepted clock also yields the two matching filter outputs. The result is the same as an M-tap direct-form filter run over the interleaved stream even0, odd0, even1, odd1 and so on.

The M coefficients are split by phase into an even-tap set and an odd-tap set. A third set holds the pairwise sums of the two, and it is formed while the design elaborates. Three half-length subfilters run once per accepted clock:

- one on the even lane,
- one on the odd lane,
- one on the lane sum.

A post-adder combines their results, and one block of delay sits on the odd-phase result. This uses three half-length filters where a plain split would need four.

Samples and coefficients are signed two's complement. Accumulation keeps full precision, so the outputs are exact.

Top module: `fast_fir2p`

## Requirements
- R1: While `rst_n` is low, and for the synchroniser stages after it rises, `out_valid` is 0 and both outputs are 0. A reset also clears all sample history, so later outputs see zeros for samples before the reset.
- R2: `out_valid` is `in_valid` delayed by exactly one clock.
- R3: Coefficient k of the response sits at bits [k*COEF_W +: COEF_W] of `COEFS`. On an accepted clock for block n, `y_even` on the next clock equals the sum over j of h(j)·s(2n−j). Here s(2i) is the even-lane sample of block i, s(2i+1) is its odd-lane sample, and samples before reset count as 0.
- R4: On the same clock, `y_odd` equals the sum over j of h(j)·s(2n+1−j).
- R5: A clock with `in_valid` low advances no history: the blocks on either side of a gap are treated as adjacent. Both outputs hold their previous values during the gap.
- R6: Full-scale input on both lanes, of either sign, gives the exact result with no wrap. The output width IN_W+COEF_W+log2(TAPS) is always enough.
- R7: A single nonzero sample followed by zeros reproduces the coefficients in order. An impulse on the even lane gives h0,h1 then h2,h3 and so on. An impulse on the odd lane gives 0,h0 then h1,h2 and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| in_valid | input | 1 | Both lane samples are valid this clock |
| x_even | input | IN_W | Earlier sample of the pair, signed |
| x_odd | input | IN_W | Later sample of the pair, signed |
| out_valid | output | 1 | Outputs hold a new result pair |
| y_even | output | IN_W+COEF_W+log2(TAPS) | Filter output at the even index, signed |
| y_odd | output | IN_W+COEF_W+log2(TAPS) | Filter output at the odd index, signed |

## Verification
The assertions take for granted that the lane inputs are known whenever `in_valid` is high. They also assume the coefficient set keeps each pairwise sum exact in COEF_W+1 bits, which is true for any signed COEF_W values. The overflow check further assumes the samples stay within their signed range.

The stimulus changes inputs only on the falling edge and keeps `in_valid` low through reset and the synchroniser delay. It draws every sample from the legal signed range, including both extremes, so the overflow and hold properties see legal traffic with gaps of varying length.

// File: rtl/fir2p_pkg.sv
package fir2p_pkg;
  // Which coefficient subset a half-length subfilter uses
  typedef enum logic [1:0] {
    PH_EVEN = 2'd0,
    PH_ODD  = 2'd1,
    PH_SUM  = 2'd2
  } phase_e;

  // Bits of growth when adding n terms
  function automatic int unsigned add_growth(input int unsigned n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction
endpackage

// File: rtl/fir2p_rst_sync.sv
module fir2p_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fir2p_subfilter.sv
module fir2p_subfilter
  import fir2p_pkg::*;
#(
  parameter int unsigned               IN_W   = 12,
  parameter int unsigned               COEF_W = 10,
  parameter int unsigned               TAPS   = 8,
  parameter logic [TAPS*COEF_W-1:0]    COEFS  = '0,
  parameter phase_e                    PHASE  = PH_EVEN,
  parameter int unsigned               SUM_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  sample,
  output logic signed [SUM_W-1:0] acc
);
  localparam int unsigned NT = TAPS / 2;
  localparam int unsigned CW = COEF_W + 1;

  logic signed [IN_W-1:0]  hist_q [NT-1];
  logic signed [IN_W-1:0]  hist_d [NT-1];
  logic signed [IN_W-1:0]  tap    [NT];
  logic signed [SUM_W-1:0] prod   [NT];

  assign tap[0] = sample;

  for (genvar k = 0; k < NT; k++) begin : g_tap
    localparam logic signed [COEF_W-1:0] CE = COEFS[2*k*COEF_W +: COEF_W];
    localparam logic signed [COEF_W-1:0] CO = COEFS[(2*k+1)*COEF_W +: COEF_W];
    localparam logic signed [CW-1:0] C =
      (PHASE == PH_SUM) ? CW'(CE) + CW'(CO) :
      (PHASE == PH_ODD) ? CW'(CO) : CW'(CE);
    if (k > 0) begin : g_from_hist
      assign tap[k] = hist_q[k-1];
    end
    assign prod[k] = SUM_W'(tap[k]) * SUM_W'(C);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NT; k++) acc = acc + prod[k];
  end

  // Delay line next state: shift one block per accepted clock
  always_comb begin
    hist_d = hist_q;
    if (en) begin
      hist_d[0] = sample;
      for (int i = 1; i < NT - 1; i++) hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NT - 1; i++) hist_q[i] <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> hist_q[0] == $past(sample));
  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(hist_q[NT-2]) && $stable(hist_q[0]));
endmodule

// File: rtl/fir2p_combine.sv
module fir2p_combine #(
  parameter int unsigned SUM_W = 32,
  parameter int unsigned OUT_W = 25
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [SUM_W-1:0] a_even,
  input  logic signed [SUM_W-1:0] a_odd,
  input  logic signed [SUM_W-1:0] a_sum,
  output logic signed [OUT_W-1:0] y_even,
  output logic signed [OUT_W-1:0] y_odd
);
  localparam logic signed [SUM_W-1:0] MAXV = (SUM_W'(1) <<< (OUT_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] MINV = -(SUM_W'(1) <<< (OUT_W - 1));

  logic signed [SUM_W-1:0] odd_dly_q, odd_dly_d;
  logic signed [SUM_W-1:0] wide_e, wide_o;
  logic signed [OUT_W-1:0] y_even_d, y_odd_d;

  always_comb begin
    wide_e    = a_even + odd_dly_q;
    wide_o    = a_sum - a_even - a_odd;
    odd_dly_d = odd_dly_q;
    y_even_d  = y_even;
    y_odd_d   = y_odd;
    if (en) begin
      odd_dly_d = a_odd;
      y_even_d  = OUT_W'(wide_e);
      y_odd_d   = OUT_W'(wide_o);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_dly_q <= '0;
      y_even    <= '0;
      y_odd     <= '0;
    end else begin
      odd_dly_q <= odd_dly_d;
      y_even    <= y_even_d;
      y_odd     <= y_odd_d;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (wide_e <= MAXV) && (wide_e >= MINV) && (wide_o <= MAXV) && (wide_o >= MINV));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y_even) && $stable(y_odd));
endmodule

// File: rtl/fast_fir2p.sv
module fast_fir2p
  import fir2p_pkg::*;
#(
  parameter int unsigned            IN_W   = 12,
  parameter int unsigned            COEF_W = 10,
  parameter int unsigned            TAPS   = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS  = {
    -10'sd9, 10'sd22, -10'sd512, -10'sd512, 10'sd300, 10'sd511, -10'sd12, 10'sd5},
  localparam int unsigned OUT_W = IN_W + COEF_W + add_growth(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  x_even,
  input  logic signed [IN_W-1:0]  x_odd,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] y_even,
  output logic signed [OUT_W-1:0] y_odd
);
  localparam int unsigned SUM_W = IN_W + COEF_W + 2 + add_growth(TAPS);

  logic                    rst_sync_n;
  logic signed [IN_W:0]    x_pair;
  logic signed [SUM_W-1:0] acc_even, acc_odd, acc_sum;
  logic                    valid_d;

  fir2p_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Pre-adder feeding the combined-coefficient subfilter
  assign x_pair = x_even + x_odd;

  fir2p_subfilter #(.IN_W(IN_W), .COEF_W(COEF_W), .TAPS(TAPS), .COEFS(COEFS),
                    .PHASE(PH_EVEN), .SUM_W(SUM_W)) u_sub_even (
    .clk(clk), .rst_n(rst_sync_n), .en(in_valid), .sample(x_even), .acc(acc_even));

  fir2p_subfilter #(.IN_W(IN_W), .COEF_W(COEF_W), .TAPS(TAPS), .COEFS(COEFS),
                    .PHASE(PH_ODD), .SUM_W(SUM_W)) u_sub_odd (
    .clk(clk), .rst_n(rst_sync_n), .en(in_valid), .sample(x_odd), .acc(acc_odd));

  fir2p_subfilter #(.IN_W(IN_W + 1), .COEF_W(COEF_W), .TAPS(TAPS), .COEFS(COEFS),
                    .PHASE(PH_SUM), .SUM_W(SUM_W)) u_sub_sum (
    .clk(clk), .rst_n(rst_sync_n), .en(in_valid), .sample(x_pair), .acc(acc_sum));

  fir2p_combine #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_post (
    .clk(clk), .rst_n(rst_sync_n), .en(in_valid),
    .a_even(acc_even), .a_odd(acc_odd), .a_sum(acc_sum),
    .y_even(y_even), .y_odd(y_odd));

  always_comb valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= valid_d;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_sync_n |-> !out_valid && (y_even == '0) && (y_odd == '0));
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
endmodule

// File: tb/tb_fast_fir2p.sv
`timescale 1ns/1ps
module tb_fast_fir2p;
  localparam int unsigned IN_W   = 12;
  localparam int unsigned COEF_W = 10;
  localparam int unsigned TAPS   = 8;
  localparam int unsigned OUT_W  = IN_W + COEF_W + $clog2(TAPS);
  localparam int H [TAPS] = '{5, -12, 511, 300, -512, -512, 22, -9};

  function automatic logic [TAPS*COEF_W-1:0] pack_coefs();
    logic [TAPS*COEF_W-1:0] r;
    r = '0;
    for (int k = 0; k < TAPS; k++) r[k*COEF_W +: COEF_W] = COEF_W'(H[k]);
    return r;
  endfunction
  localparam logic [TAPS*COEF_W-1:0] CF = pack_coefs();

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [IN_W-1:0]  x_even, x_odd;
  logic                    out_valid;
  logic signed [OUT_W-1:0] y_even, y_odd;

  int n_checks = 0;
  int n_fail   = 0;
  longint hist[$];
  longint exp_e = 0, exp_o = 0;
  logic   exp_v = 1'b0;

  always #2.5 clk = ~clk;

  fast_fir2p #(.IN_W(IN_W), .COEF_W(COEF_W), .TAPS(TAPS), .COEFS(CF)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_even(x_even), .x_odd(x_odd),
    .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd));

  function automatic longint conv();
    longint s = 0;
    for (int j = 0; j < TAPS && j < hist.size(); j++) s += longint'(H[j]) * hist[j];
    return s;
  endfunction

  task automatic push_sample(input longint v);
    hist.push_front(v);
    if (hist.size() > TAPS) void'(hist.pop_back());
  endtask

  task automatic check(input string tag, input longint act, input longint expv, input string what);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Drive one clock of stimulus at the falling edge, check at the next falling edge
  task automatic step(input logic v, input int xe, input int xo, input string te, input string tod);
    in_valid = v;
    x_even   = IN_W'(xe);
    x_odd    = IN_W'(xo);
    exp_v    = v;
    if (v) begin
      push_sample(xe); exp_e = conv();
      push_sample(xo); exp_o = conv();
    end
    @(negedge clk);
    check("R2", longint'(out_valid), longint'(exp_v), "out_valid");
    check(v ? te : "R5", longint'(y_even), exp_e, "y_even");
    check(v ? tod : "R5", longint'(y_odd), exp_o, "y_odd");
  endtask

  task automatic idle_after_reset();
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 0, 0, "R1", "R1");
    end
    check("R1", longint'(y_even), 0, "y_even after reset");
    check("R1", longint'(y_odd), 0, "y_odd after reset");
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog R2: got no end of stimulus expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; x_even = '0; x_odd = '0;
    repeat (3) @(negedge clk);
    check("R1", longint'(out_valid), 0, "out_valid in reset");
    check("R1", longint'(y_even), 0, "y_even in reset");
    check("R1", longint'(y_odd), 0, "y_odd in reset");
    rst_n = 1'b1;
    idle_after_reset();

    // R7: impulse on the even lane, then on the odd lane
    step(1'b1, 1, 0, "R7", "R7");
    for (int i = 0; i < 5; i++) step(1'b1, 0, 0, "R7", "R7");
    step(1'b1, 0, 1, "R7", "R7");
    for (int i = 0; i < 5; i++) step(1'b1, 0, 0, "R7", "R7");

    // R3/R4/R5: random samples with random gaps
    for (int i = 0; i < 400; i++) begin
      logic v;
      v = ($urandom_range(0, 3) != 0);
      step(v, $urandom_range(0, 4095) - 2048, $urandom_range(0, 4095) - 2048, "R3", "R4");
    end

    // R6: full-scale negative, full-scale positive, sign-matched worst case
    for (int i = 0; i < 8; i++) step(1'b1, -2048, -2048, "R6", "R6");
    for (int i = 0; i < 8; i++) step(1'b1, 2047, 2047, "R6", "R6");
    for (int i = 0; i < 12; i++)
      step(1'b1, (i % 2 == 0) ? 2047 : -2048, (i % 3 == 0) ? -2048 : 2047, "R6", "R6");

    // R1: asynchronous reset mid-stream clears outputs and history
    for (int i = 0; i < 3; i++) step(1'b1, 1000 - i, -700 + i, "R3", "R4");
    #1 rst_n = 1'b0; in_valid = 1'b0;
    #1;
    check("R1", longint'(out_valid), 0, "out_valid async reset");
    check("R1", longint'(y_even), 0, "y_even async reset");
    check("R1", longint'(y_odd), 0, "y_odd async reset");
    hist.delete(); exp_e = 0; exp_o = 0; exp_v = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle_after_reset();
    step(1'b1, 0, 1, "R1", "R1");
    for (int i = 0; i < 5; i++) step(1'b1, 0, 0, "R1", "R1");

    finish_run();
  end
endmodule